// File: doc/BRIEF.md
# Interrupt redirection router with deferred masked-level replay

This block routes sixteen interrupt input lines to a single delivery port. Each line owns a 64-bit redirection entry that holds a vector, a destination, a mask bit, a trigger-mode bit, a destination-mode bit and a delivery-mode field. Software reaches the entries through an indirect pair of 32-bit registers. A select register at offset 0x00 names a register, and a window at offset 0x10 reads or writes the register that was named.

The block reacts only to changes of line level. A line that goes high raises a delivery request when its entry is unmasked and uses fixed delivery to a physical destination. Requests from several lines are served lowest line first. Each request is presented on a valid/ready port until the consumer accepts it.

A level-triggered line that goes high while its entry is masked is not lost. The block marks the entry as pending. The next write to that entry that leaves it unmasked clears the mark, and if the line is still high at that write, a delivery request is raised exactly as if the line had dropped and risen again.

Top module: `irq_router`

## Requirements
- R1: After reset every entry reads 0x0001000000010000 (both halves 0x00010000, so every line is masked), the select register reads 0, no request is presented and no entry is pending.
- R2: A write at offset 0x00 loads the 32-bit select value. A read strobe at offset 0x00 returns it on bus_rdata after the next clock edge, and bus_rdata holds its value until the next read strobe. Reads at any offset other than 0x00 and 0x10 return 0.
- R3: Select index 0x10+2n names the low half (bits 31:0) of entry n, and 0x11+2n names its high half (bits 63:32). Through the window, any other index reads 0 and ignores writes.
- R4: A window write replaces only the addressed 32-bit half of an entry. The other half keeps its contents.
- R5: A low-to-high change of line n whose entry has mask bit 16 = 0, destination-mode bit 11 = 0 and delivery-mode bits 10:8 = 000 raises a request. The request presents dlv_pin = n, dlv_vector = entry bits 7:0 and dlv_dest = entry bits 63:56, taken from the entry at the moment the request is granted. dlv_valid rises after the second clock edge that sees the new level, when the port is free.
- R6: A rising line raises no request if its entry has mask bit 16 set, destination-mode bit 11 set, or a delivery mode other than 000.
- R7: A falling line, or a line that keeps its level, never raises a request. A new request for a line that already has one waiting merges with it.
- R8: A line that rises while its entry is masked with trigger-mode bit 15 = 1 (level) becomes pending. With bit 15 = 0 (edge) it does not.
- R9: When an entry is pending and a window write leaves mask bit 16 clear, the pending mark is cleared. If the line is high at that edge and the updated entry is fixed and physical, a request is raised, and dlv_valid rises one edge after the write when the port is free. If the line is low, no request is raised and the mark stays cleared.
- R10: When several requests wait, the lowest-numbered line is granted first.
- R11: While dlv_valid is high and dlv_ready is low, dlv_valid, dlv_pin, dlv_vector and dlv_dest hold steady.
- R12: Reads have no side effect on the pending marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register offset (0x00 select, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_pin | input | 16 | Interrupt input lines, active high |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Consumer accepts the presented request |
| dlv_pin | output | 4 | Line number of the presented request |
| dlv_vector | output | 8 | Vector of the presented request |
| dlv_dest | output | 8 | Physical destination of the presented request |

## Verification
Read data is due one edge after the read strobe. A line edge is due on the delivery port two edges after the level changes: one edge to register the level and the request flag, and one to load the output register. An unmask replay is due one edge after the write, because the write edge already sets the request flag. The bench holds a behavioural model that advances on the same rising edge as the design. It compares bus_rdata and the whole delivery port with that model at every falling edge, so no result is sampled in the wrong cycle. The directed checks wait exactly those numbers of falling edges after each stimulus before they sample.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int BUS_W   = 32;
  localparam int ENT_W   = 2 * BUS_W;
  // control field positions inside an entry
  localparam int B_MASK  = 16;
  localparam int B_TRIG  = 15;
  localparam int B_DMODE = 11;
  localparam int B_DLV_H = 10;
  localparam int B_DLV_L = 8;
  localparam int B_DEST  = 56;
  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0001_0000_0001_0000;

  // fixed delivery to a physical target with the mask clear
  function automatic logic can_fwd(logic mask, logic dmode, logic [2:0] dmod);
    return !mask && !dmode && (dmod == 3'b000);
  endfunction
endpackage

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_router_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFF_SEL = 8'h00,
  parameter logic [AW-1:0] OFF_WIN = 8'h10,
  parameter logic [BUS_W-1:0] TAB_BASE = 32'h10,
  localparam int PW = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [NPIN-1:0]  wr_hit,
  output logic [NPIN-1:0]  mask_q,
  output logic [NPIN-1:0]  level_q,
  output logic [NPIN-1:0]  fwd_q,
  output logic [NPIN-1:0]  mask_nxt,
  output logic [NPIN-1:0]  fwd_nxt,
  output logic [7:0]       vec_q  [NPIN],
  output logic [7:0]       dest_q [NPIN]
);
  localparam logic [BUS_W-1:0] TAB_END = TAB_BASE + BUS_W'(2 * NPIN);

  logic [BUS_W-1:0] sel_q;
  logic [ENT_W-1:0] tab_q   [NPIN];
  logic [ENT_W-1:0] tab_nxt [NPIN];
  logic             in_tab;
  logic             hi_half;
  logic [PW-1:0]    ent;
  logic             win_wr;

  assign in_tab  = (sel_q >= TAB_BASE) && (sel_q < TAB_END);
  assign hi_half = sel_q[0] ^ TAB_BASE[0];
  assign ent     = sel_q[PW:1] - TAB_BASE[PW:1];
  assign win_wr  = bus_wr && (bus_addr == OFF_WIN) && in_tab;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      tab_nxt[i] = tab_q[i];
      wr_hit[i]  = win_wr && (ent == PW'(i));
      if (wr_hit[i]) begin
        if (hi_half) tab_nxt[i][ENT_W-1:BUS_W] = bus_wdata;
        else         tab_nxt[i][BUS_W-1:0]     = bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      bus_rdata <= '0;
      for (int i = 0; i < NPIN; i++) tab_q[i] <= ENT_RESET;
    end else begin
      for (int i = 0; i < NPIN; i++) tab_q[i] <= tab_nxt[i];
      if (bus_wr && bus_addr == OFF_SEL) sel_q <= bus_wdata;
      if (bus_rd) begin
        if (bus_addr == OFF_SEL)
          bus_rdata <= sel_q;
        else if (bus_addr == OFF_WIN && in_tab)
          bus_rdata <= hi_half ? tab_q[ent][ENT_W-1:BUS_W] : tab_q[ent][BUS_W-1:0];
        else
          bus_rdata <= '0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_fields
      assign mask_q[g]   = tab_q[g][B_MASK];
      assign level_q[g]  = tab_q[g][B_TRIG];
      assign fwd_q[g]    = can_fwd(tab_q[g][B_MASK], tab_q[g][B_DMODE], tab_q[g][B_DLV_H:B_DLV_L]);
      assign mask_nxt[g] = tab_nxt[g][B_MASK];
      assign fwd_nxt[g]  = can_fwd(tab_nxt[g][B_MASK], tab_nxt[g][B_DMODE], tab_nxt[g][B_DLV_H:B_DLV_L]);
      assign vec_q[g]    = tab_q[g][7:0];
      assign dest_q[g]   = tab_q[g][ENT_W-1:B_DEST];

      // a write to one half leaves the other half untouched (R4)
      assert_half_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit[g] && !hi_half) |=> (tab_q[g][ENT_W-1:BUS_W] == $past(tab_q[g][ENT_W-1:BUS_W])));
    end
  endgenerate
endmodule

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] wr_hit,
  input  logic [NPIN-1:0] mask_q,
  input  logic [NPIN-1:0] level_q,
  input  logic [NPIN-1:0] fwd_q,
  input  logic [NPIN-1:0] mask_nxt,
  input  logic [NPIN-1:0] fwd_nxt,
  input  logic [NPIN-1:0] grant_clr,
  output logic [NPIN-1:0] req_q
);
  logic [NPIN-1:0] lvl_q;
  logic [NPIN-1:0] pend_q;
  logic [NPIN-1:0] rise;
  logic [NPIN-1:0] set_pend;
  logic [NPIN-1:0] clr_pend;
  logic [NPIN-1:0] replay;
  logic [NPIN-1:0] new_req;

  assign rise     = pin_in & ~lvl_q;
  assign set_pend = rise & mask_q & level_q;
  assign clr_pend = wr_hit & pend_q & ~mask_nxt;
  assign replay   = clr_pend & pin_in & fwd_nxt;
  assign new_req  = (rise & fwd_q) | replay;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      lvl_q  <= pin_in;
      pend_q <= (pend_q & ~clr_pend) | set_pend;
      req_q  <= (req_q & ~grant_clr) | new_req;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_chk
      // a request flag appears only after a rising line or an entry write (R7)
      assert_req_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q[g]) |-> $past((pin_in[g] && !lvl_q[g]) || wr_hit[g]));
      // pending is only taken while the entry is masked (R8)
      assert_pend_masked_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q[g]) |-> $past(mask_q[g] && pin_in[g]));
      // an unmasking write drops the pending mark (R9)
      assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_hit[g] && pend_q[g] && !mask_nxt[g] && !(pin_in[g] && !lvl_q[g])) |=> !pend_q[g]);
    end
  endgenerate
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NPIN = 16,
  localparam int PW = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] req,
  input  logic [7:0]      vec_i  [NPIN],
  input  logic [7:0]      dest_i [NPIN],
  input  logic            dlv_ready,
  output logic [NPIN-1:0] grant_clr,
  output logic            dlv_valid,
  output logic [PW-1:0]   dlv_pin,
  output logic [7:0]      dlv_vector,
  output logic [7:0]      dlv_dest
);
  logic          take;
  logic          any;
  logic [PW-1:0] pick;

  assign take = !dlv_valid || dlv_ready;
  assign any  = |req;

  always_comb begin
    pick      = '0;
    grant_clr = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (req[i]) pick = PW'(i);
    end
    if (take && any) grant_clr[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_pin    <= '0;
      dlv_vector <= '0;
      dlv_dest   <= '0;
    end else if (take) begin
      dlv_valid <= any;
      if (any) begin
        dlv_pin    <= pick;
        dlv_vector <= vec_i[pick];
        dlv_dest   <= dest_i[pick];
      end
    end
  end

  // a held request does not move (R11)
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) && $stable(dlv_vector) && $stable(dlv_dest)));
  // a free port with a waiting request always presents one (R10)
  assert_grant_free_R10: assert property (@(posedge clk) disable iff (rst)
    (take && any) |=> dlv_valid);
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NPIN = 16,
  parameter int AW = 8,
  localparam int PW = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] irq_pin,
  output logic            dlv_valid,
  input  logic            dlv_ready,
  output logic [PW-1:0]   dlv_pin,
  output logic [7:0]      dlv_vector,
  output logic [7:0]      dlv_dest
);
  logic [NPIN-1:0] wr_hit, mask_q, level_q, fwd_q, mask_nxt, fwd_nxt;
  logic [NPIN-1:0] req, grant_clr;
  logic [7:0]      vec_q  [NPIN];
  logic [7:0]      dest_q [NPIN];

  irq_regwin #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_hit(wr_hit), .mask_q(mask_q), .level_q(level_q), .fwd_q(fwd_q),
    .mask_nxt(mask_nxt), .fwd_nxt(fwd_nxt), .vec_q(vec_q), .dest_q(dest_q)
  );

  irq_pin_track #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst(rst), .pin_in(irq_pin), .wr_hit(wr_hit),
    .mask_q(mask_q), .level_q(level_q), .fwd_q(fwd_q),
    .mask_nxt(mask_nxt), .fwd_nxt(fwd_nxt), .grant_clr(grant_clr), .req_q(req)
  );

  irq_arb #(.NPIN(NPIN)) u_arb (
    .clk(clk), .rst(rst), .req(req), .vec_i(vec_q), .dest_i(dest_q),
    .dlv_ready(dlv_ready), .grant_clr(grant_clr), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest)
  );
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pins = '0;
  logic        ready = 1'b1;
  logic        valid;
  logic [3:0]  dpin;
  logic [7:0]  dvec, ddest;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_pin(pins), .dlv_valid(valid),
    .dlv_ready(ready), .dlv_pin(dpin), .dlv_vector(dvec), .dlv_dest(ddest)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_tab [16];
  logic [63:0] n_tab [16];
  logic [31:0] m_sel, m_rdata;
  logic [15:0] m_lvl, m_pend, m_req, n_req, n_pend, hit;
  logic        m_valid;
  int          m_pin, found, ent;
  logic [7:0]  m_vec, m_dest;
  bit          intab, rise_b;

  function automatic bit fwd_ok(logic [63:0] e);
    return !e[16] && !e[11] && (e[10:8] == 3'b000);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_tab[i] = 64'h0001000000010000;
      m_sel = 0; m_rdata = 0; m_lvl = 0; m_pend = 0; m_req = 0;
      m_valid = 0; m_pin = 0; m_vec = 0; m_dest = 0;
    end else begin
      intab = (m_sel >= 32'h10) && (m_sel < 32'h30);
      ent = intab ? int'((m_sel - 32'h10) / 2) : 0;
      if (rd) begin
        if (addr == 8'h00) m_rdata = m_sel;
        else if (addr == 8'h10 && intab) m_rdata = m_sel[0] ? m_tab[ent][63:32] : m_tab[ent][31:0];
        else m_rdata = 0;
      end
      for (int i = 0; i < 16; i++) n_tab[i] = m_tab[i];
      hit = 0;
      if (wr && addr == 8'h10 && intab) begin
        hit[ent] = 1'b1;
        if (m_sel[0]) n_tab[ent][63:32] = wdata; else n_tab[ent][31:0] = wdata;
      end
      n_req = m_req;
      if (!m_valid || ready) begin
        found = -1;
        for (int i = 0; i < 16; i++) if (m_req[i] && found < 0) found = i;
        if (found >= 0) begin
          m_valid = 1; m_pin = found; m_vec = m_tab[found][7:0];
          m_dest = m_tab[found][63:56]; n_req[found] = 1'b0;
        end else m_valid = 0;
      end
      n_pend = m_pend;
      for (int i = 0; i < 16; i++) begin
        rise_b = pins[i] && !m_lvl[i];
        if (rise_b && fwd_ok(m_tab[i])) n_req[i] = 1'b1;
        if (hit[i] && m_pend[i] && !n_tab[i][16]) begin
          n_pend[i] = 1'b0;
          if (pins[i] && fwd_ok(n_tab[i])) n_req[i] = 1'b1;
        end
        if (rise_b && m_tab[i][16] && m_tab[i][15]) n_pend[i] = 1'b1;
      end
      if (wr && addr == 8'h00) m_sel = wdata;
      for (int i = 0; i < 16; i++) m_tab[i] = n_tab[i];
      m_req = n_req; m_pend = n_pend; m_lvl = pins;
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (rdata !== m_rdata) begin
        bad++; $display("FAIL R2 rdata act=%h exp=%h", rdata, m_rdata);
      end
      total++;
      if (valid !== m_valid) begin
        bad++; $display("FAIL R5 dlv_valid act=%b exp=%b", valid, m_valid);
      end else if (valid) begin
        total++;
        if (dpin !== 4'(m_pin) || dvec !== m_vec || ddest !== m_dest) begin
          bad++;
          $display("FAIL R10 dlv act=%0d/%h/%h exp=%0d/%h/%h", dpin, dvec, ddest, m_pin, m_vec, m_dest);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    tick();
    wr = 0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    rd = 1; addr = a;
    tick();
    rd = 0;
    d = rdata;
  endtask

  task automatic ent_write(int idx, logic [31:0] d);
    bus_write(8'h00, 32'(idx));
    bus_write(8'h10, d);
  endtask

  task automatic ent_read(int idx, output logic [31:0] d);
    bus_write(8'h00, 32'(idx));
    bus_read(8'h10, d);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] r;
    tick(3);
    rst = 0;
    tick();
    check("R1 valid after reset", 64'(valid), 0);
    ent_read(8'h16, r); check("R1 entry3 low", 64'(r), 64'h00010000);
    ent_read(8'h17, r); check("R1 entry3 high", 64'(r), 64'h00010000);
    ent_read(8'h2F, r); check("R1 entry15 high", 64'(r), 64'h00010000);
    bus_read(8'h00, r); check("R2 select readback", 64'(r), 64'h2F);
    bus_read(8'h08, r); check("R2 other offset reads 0", 64'(r), 0);
    ent_write(8'h05, 32'hDEAD_BEEF);
    bus_read(8'h10, r); check("R3 unimplemented index", 64'(r), 0);
    ent_read(8'h30, r); check("R3 index past table", 64'(r), 0);

    // R4: half write
    ent_write(8'h15, 32'hA500_0000);
    ent_read(8'h15, r); check("R4 high half written", 64'(r), 64'hA5000000);
    ent_read(8'h14, r); check("R4 low half kept", 64'(r), 64'h00010000);

    // R5 / R11: delivery and hold
    ent_write(8'h14, 32'h0000_0042);
    ready = 0;
    pins[2] = 1;
    tick(2);
    check("R5 valid", 64'(valid), 1);
    check("R5 pin", 64'(dpin), 2);
    check("R5 vector", 64'(dvec), 64'h42);
    check("R5 dest", 64'(ddest), 64'hA5);
    tick(3);
    check("R11 still valid", 64'(valid), 1);
    check("R11 vector held", 64'(dvec), 64'h42);
    ready = 1;
    tick();
    check("R11 released", 64'(valid), 0);
    pins[2] = 0;
    tick(3);
    check("R7 fall no delivery", 64'(valid), 0);

    // R6: non-qualifying entries
    ent_write(8'h18, 32'h0000_0844);
    ent_write(8'h1A, 32'h0000_0145);
    ent_write(8'h1C, 32'h0001_0046);
    pins[6:4] = 3'b111;
    tick(3);
    check("R6 logical/non-fixed/masked", 64'(valid), 0);
    ent_write(8'h1C, 32'h0000_0046);
    tick(2);
    check("R8 masked edge not pending", 64'(valid), 0);

    // R8 / R9 / R12: masked level pending replay
    ent_write(8'h1E, 32'h0001_8047);
    pins[7] = 1;
    tick(3);
    check("R8 masked level no delivery", 64'(valid), 0);
    ent_read(8'h1E, r); check("R12 read entry", 64'(r), 64'h00018047);
    bus_write(8'h10, 32'h0000_8047);
    tick();
    check("R9 replay valid", 64'(valid), 1);
    check("R9 replay vector", 64'(dvec), 64'h47);
    tick(2);

    // R9: pending cleared with line low
    ent_write(8'h20, 32'h0001_8048);
    pins[8] = 1; tick(2);
    pins[8] = 0; tick(2);
    ent_write(8'h20, 32'h0000_8048);
    tick(2);
    check("R9 low line no delivery", 64'(valid), 0);
    ent_write(8'h20, 32'h0001_0048);
    pins[8] = 1; tick(2);
    ent_write(8'h20, 32'h0000_0048);
    tick(2);
    check("R9 pending stays cleared", 64'(valid), 0);

    // R10: fixed priority
    ent_write(8'h22, 32'h0000_0049);
    ent_write(8'h24, 32'h0000_004A);
    ent_write(8'h26, 32'h0000_004B);
    ready = 0;
    pins[11:9] = 3'b111;
    tick(2);
    check("R10 first grant pin", 64'(dpin), 9);
    ready = 1;
    tick();
    check("R10 second grant pin", 64'(dpin), 10);
    tick();
    check("R10 third grant pin", 64'(dpin), 11);
    tick();
    check("R10 drained", 64'(valid), 0);
    pins[11:9] = 3'b000;
    tick(2);
    pins[9] = 1;
    tick(2);
    check("R7 rerise delivers once", 64'(dpin), 9);
    tick(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule